// File: doc/BRIEF.md
# Memory-Mapped PWM Timer Channel

This block is one timer channel hung on a simple word-addressed register bus. A 24-bit up-counter advances by one on every clock while counting is enabled. Two reference registers, a high mark and a low mark, shape its cycle. When the count equals the low mark, the counter returns to zero on the next clock, so each period lasts low-mark-plus-one clocks. The PWM pin is high while the count is below the high mark. A sticky status flag records compare events and drives an interrupt line through a global enable.

Software normally loads both marks with the same period, clears the counter and writes one control word that enables counting, the pin and the interrupt. The interrupt service routine acknowledges the flag by writing one to the status bit, and it may restart the channel. A single-shot mode makes the channel stop itself after the first low-mark wrap. Writing zero to the control word halts the channel and masks its interrupt.

Top module: `pwm_timer_chan`

## Requirements
- R1: `bus_rdata` shows, without a clock delay, the register selected by `bus_addr`: 0x0 the live count (zero-extended), 0x4 the high mark, 0x8 the low mark, 0xC the control word. Any other address reads zero. In the control word only bits 0, 3, 4, 5, 6, 10 and 11 can read as one.
- R2: While control bit 0 is set, the count increases by one per clock. If the count equals the low mark, it becomes zero on the next clock instead. Above 0xFFFFFF the count wraps to zero.
- R3: With control bit 4 set, a low-mark wrap also clears control bit 0, so the count rests at zero.
- R4: The status flag (control bit 6) is set by a low-mark wrap when bit 11 is set or when bits 10 and 11 are both clear. It is set by a high-mark match (count equals the high mark while counting) when bit 10 is set.
- R5: A control write with bit 6 at one clears the status flag. A control write with bit 6 at zero leaves it unchanged. A status-setting event in the same clock as the clear leaves the flag set.
- R6: `irq_out` is high exactly when the status flag and control bit 5 are both one.
- R7: `pwm_out` is high exactly when control bit 3 is one and the count is below the high mark.
- R8: A write to 0x0 loads the count from the low 24 data bits, and this takes priority over counting. A control write with bit 7 set clears the count. Bit 7 always reads zero.
- R9: Writing zero to the control word stops counting and holds `irq_out` low. The status flag keeps its value.
- R10: A synchronous active-high `rst` clears the count, both marks, the control word and the status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 4 | Byte offset of the register to read or write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pwm_out | output | 1 | PWM output pin |
| irq_out | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is an acknowledge that lands in the same clock as a new compare event. The bench forces this case by programming a low mark of zero, so a wrap happens on every running clock. It then writes the acknowledge while counting is still on, followed by a stopped write that finds the channel still running at that edge. A second hard case is the 24-bit rollover at the top of the range: the bench preloads the count just below it. Random register traffic with small marks covers the remaining interleavings, and every output is compared on every cycle against a model kept in the bench.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  localparam int BUS_W  = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFF_COUNT = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_HIGH  = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_LOW   = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 4'hC;

  localparam int BIT_RUN  = 0;
  localparam int BIT_OUT  = 3;
  localparam int BIT_ONCE = 4;
  localparam int BIT_IRQ  = 5;
  localparam int BIT_STAT = 6;
  localparam int BIT_ZERO = 7;
  localparam int BIT_HIE  = 10;
  localparam int BIT_LIE  = 11;

  typedef struct packed {
    logic lo_ie;
    logic hi_ie;
    logic irq_en;
    logic once;
    logic out_en;
    logic run;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [BUS_W-1:0] w);
    ctrl_t c;
    c.run    = w[BIT_RUN];
    c.out_en = w[BIT_OUT];
    c.once   = w[BIT_ONCE];
    c.irq_en = w[BIT_IRQ];
    c.hi_ie  = w[BIT_HIE];
    c.lo_ie  = w[BIT_LIE];
    return c;
  endfunction

  function automatic logic [BUS_W-1:0] ctrl_to_word(input ctrl_t c, input logic stat);
    logic [BUS_W-1:0] w;
    w           = '0;
    w[BIT_RUN]  = c.run;
    w[BIT_OUT]  = c.out_en;
    w[BIT_ONCE] = c.once;
    w[BIT_IRQ]  = c.irq_en;
    w[BIT_STAT] = stat;
    w[BIT_HIE]  = c.hi_ie;
    w[BIT_LIE]  = c.lo_ie;
    return w;
  endfunction

  // sticky flag: a new event beats a clear in the same cycle
  function automatic logic status_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // which compare events feed the status flag
  function automatic logic status_source(input ctrl_t c, input logic hi_evt, input logic lo_evt);
    return (lo_evt & (c.lo_ie | ~c.hi_ie)) | (hi_evt & c.hi_ie);
  endfunction

endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [BUS_W-1:0]     wr_data,
  input  logic                 stat_set,
  input  logic                 once_stop,
  output ctrl_t                ctrl,
  output logic                 stat,
  output logic [CNT_W-1:0]     hi_ref,
  output logic [CNT_W-1:0]     lo_ref,
  output logic                 ctrl_wr,
  output logic                 cnt_wr,
  output logic                 cnt_zero,
  output logic                 ack
);

  logic hi_wr, lo_wr;

  assign ctrl_wr  = wr_en && (wr_addr == OFF_CTRL);
  assign cnt_wr   = wr_en && (wr_addr == OFF_COUNT);
  assign hi_wr    = wr_en && (wr_addr == OFF_HIGH);
  assign lo_wr    = wr_en && (wr_addr == OFF_LOW);
  assign ack      = ctrl_wr && wr_data[BIT_STAT];
  assign cnt_zero = ctrl_wr && wr_data[BIT_ZERO];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      stat   <= 1'b0;
      hi_ref <= '0;
      lo_ref <= '0;
    end else begin
      if (hi_wr) hi_ref <= wr_data[CNT_W-1:0];
      if (lo_wr) lo_ref <= wr_data[CNT_W-1:0];
      if (ctrl_wr)        ctrl     <= ctrl_from_word(wr_data);
      else if (once_stop) ctrl.run <= 1'b0;
      stat <= status_next(stat, stat_set, ack);
    end
  end

endmodule

// File: rtl/pwm_timer_cnt.sv
module pwm_timer_cnt #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] hi_ref,
  input  logic [CNT_W-1:0] lo_ref,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             zero,
  output logic [CNT_W-1:0] cnt,
  output logic             hi_evt,
  output logic             lo_evt
);

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] c, input logic wrap);
    return wrap ? '0 : c + 1'b1;
  endfunction

  assign hi_evt = run && (cnt == hi_ref);
  assign lo_evt = run && (cnt == lo_ref);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (zero) cnt <= '0;
    else if (run)  cnt <= advance(cnt, lo_evt);
  end

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        pwm_out,
  output logic        irq_out
);

  localparam int PAD_W = BUS_W - CNT_W;

  ctrl_t            ctl;
  logic             stat, stat_set, once_stop;
  logic             ctrl_wr, cnt_wr, cnt_zero, ack;
  logic             hi_evt, lo_evt;
  logic [CNT_W-1:0] hi_ref, lo_ref, cnt;
  logic             ctl_run, ctl_once, ctl_out, ctl_irq;

  assign ctl_run  = ctl.run;
  assign ctl_once = ctl.once;
  assign ctl_out  = ctl.out_en;
  assign ctl_irq  = ctl.irq_en;

  assign stat_set  = status_source(ctl, hi_evt, lo_evt);
  assign once_stop = lo_evt && ctl.once;

  pwm_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .stat_set(stat_set), .once_stop(once_stop),
    .ctrl(ctl), .stat(stat), .hi_ref(hi_ref), .lo_ref(lo_ref),
    .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr), .cnt_zero(cnt_zero), .ack(ack)
  );

  pwm_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(ctl.run),
    .hi_ref(hi_ref), .lo_ref(lo_ref),
    .load(cnt_wr), .load_val(bus_wdata[CNT_W-1:0]), .zero(cnt_zero),
    .cnt(cnt), .hi_evt(hi_evt), .lo_evt(lo_evt)
  );

  always_comb begin
    case (bus_addr)
      OFF_COUNT: bus_rdata = {{PAD_W{1'b0}}, cnt};
      OFF_HIGH:  bus_rdata = {{PAD_W{1'b0}}, hi_ref};
      OFF_LOW:   bus_rdata = {{PAD_W{1'b0}}, lo_ref};
      OFF_CTRL:  bus_rdata = ctrl_to_word(ctl, stat);
      default:   bus_rdata = '0;
    endcase
  end

  assign pwm_out = ctl.out_en && (cnt < hi_ref);
  assign irq_out = stat && ctl.irq_en;

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             once,
  input logic             out_en,
  input logic [CNT_W-1:0] cnt,
  input logic             lo_evt,
  input logic             stat_set,
  input logic             ack,
  input logic             stat,
  input logic             ctrl_wr,
  input logic             cnt_wr,
  input logic             cnt_zero,
  input logic             pwm_out,
  input logic             irq_out
);

  AST_LOW_WRAP: assert property (@(posedge clk) disable iff (rst)
    (lo_evt && !cnt_wr && !cnt_zero) |=> (cnt == '0)); // R2

  AST_ONCE_HALT: assert property (@(posedge clk) disable iff (rst)
    (lo_evt && once && !ctrl_wr) |=> !run); // R3

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
    stat_set |=> stat); // R5

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack && !stat_set) |=> !stat); // R5

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> stat); // R6

  AST_PWM_GATED: assert property (@(posedge clk) disable iff (rst)
    !out_en |-> !pwm_out); // R7

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !stat && !run)); // R10

endmodule

bind pwm_timer_chan pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(ctl_run), .once(ctl_once), .out_en(ctl_out),
  .cnt(cnt), .lo_evt(lo_evt), .stat_set(stat_set), .ack(ack), .stat(stat),
  .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr), .cnt_zero(cnt_zero),
  .pwm_out(pwm_out), .irq_out(irq_out)
);

// File: tb/tb_pwm_timer_chan.sv
module tb_pwm_timer_chan;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out, irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_timer_chan dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .irq_out(irq_out)
  );

  // bench-side model built from the requirements
  logic [23:0] m_cnt, m_hi, m_lo;
  logic m_run, m_oe, m_once, m_ie, m_hie, m_lie, m_stat;

  always @(posedge clk) begin
    logic lo_hit, hi_hit, setf, cw;
    if (rst) begin
      m_cnt = '0; m_hi = '0; m_lo = '0;
      {m_run, m_oe, m_once, m_ie, m_hie, m_lie, m_stat} = '0;
    end else begin
      lo_hit = m_run && (m_cnt == m_lo);
      hi_hit = m_run && (m_cnt == m_hi);
      setf   = (lo_hit && (m_lie || !m_hie)) || (hi_hit && m_hie);
      cw     = bus_wr && bus_addr == 4'hC;
      if (bus_wr && bus_addr == 4'h0)  m_cnt = bus_wdata[23:0];
      else if (cw && bus_wdata[7])     m_cnt = '0;
      else if (m_run)                  m_cnt = lo_hit ? 24'd0 : m_cnt + 24'd1;
      if (bus_wr && bus_addr == 4'h4) m_hi = bus_wdata[23:0];
      if (bus_wr && bus_addr == 4'h8) m_lo = bus_wdata[23:0];
      m_stat = setf || (m_stat && !(cw && bus_wdata[6]));
      if (cw) begin
        m_run = bus_wdata[0]; m_oe = bus_wdata[3]; m_once = bus_wdata[4];
        m_ie = bus_wdata[5]; m_hie = bus_wdata[10]; m_lie = bus_wdata[11];
      end else if (lo_hit && m_once) m_run = 1'b0;
    end
  end

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a)
      4'h0: return {8'h0, m_cnt};
      4'h4: return {8'h0, m_hi};
      4'h8: return {8'h0, m_lo};
      4'hC: return {20'h0, m_lie, m_hie, 3'b000, m_stat, m_ie, m_once, m_oe, 2'b00, m_run};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check({31'h0, pwm_out}, {31'h0, m_oe && (m_cnt < m_hi)}, "R7 pwm level");
      check({31'h0, irq_out}, {31'h0, m_stat && m_ie}, "R6 irq level");
      if (bus_addr == 4'h0) check(bus_rdata, exp_read(bus_addr), "R2 live count");
      else                  check(bus_rdata, exp_read(bus_addr), "R1 readback");
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [3:0]  a;
    void'($urandom(32'h5eed1234));
    idle(3); rst = 1'b0;

    // R10 reset state
    rd(4'hC, v); check(v, 32'h0, "R10 ctrl after reset");
    rd(4'h0, v); check(v, 32'h0, "R10 count after reset");
    check({31'h0, irq_out}, 32'h0, "R10 irq after reset");

    // R1 readback, reserved bits and unmapped address
    wr(4'h4, 32'hFF123456); rd(4'h4, v); check(v, 32'h00123456, "R1 high mark");
    wr(4'h8, 32'h00ABCDEF); rd(4'h8, v); check(v, 32'h00ABCDEF, "R1 low mark");
    wr(4'hC, 32'hFFFFFFFF); rd(4'hC, v); check(v, 32'h00000C39, "R1 ctrl reserved zero");
    rd(4'h2, v); check(v, 32'h0, "R1 unmapped");

    // R9 write zero stops the channel
    wr(4'hC, 32'h0); rd(4'h0, v); idle(5);
    begin logic [31:0] w; rd(4'h0, w); check(w, v, "R9 count frozen"); end

    // R8 counter load and clear bit
    wr(4'h0, 32'd100); rd(4'h0, v); check(v, 32'd100, "R8 load");
    wr(4'hC, 32'h80); rd(4'h0, v); check(v, 32'd0, "R8 clear bit");
    rd(4'hC, v); check(v, 32'h0, "R8 bit7 reads zero");

    // R2 rollover at the top of the range
    wr(4'h8, 32'hFFFFFF); wr(4'h4, 32'hFFFFFF); wr(4'h0, 32'hFFFFFE);
    wr(4'hC, 32'h1);
    rd(4'h0, v); check(v, 32'hFFFFFF, "R2 top value");
    rd(4'h0, v); check(v, 32'h0, "R2 wrap to zero");
    wr(4'hC, 32'h0);

    // R3 single-shot
    wr(4'h4, 32'd3); wr(4'h8, 32'd3); wr(4'h0, 32'd0);
    wr(4'hC, 32'h31); idle(12);
    rd(4'hC, v); check(v, 32'h70, "R3 run cleared after wrap");
    rd(4'h0, v); check(v, 32'h0, "R3 count rests at zero");
    check({31'h0, irq_out}, 32'h1, "R3 irq after one shot");
    wr(4'hC, 32'h40);

    // R4 high mark as the source
    wr(4'h4, 32'd2); wr(4'h8, 32'd10); wr(4'h0, 32'd0);
    wr(4'hC, 32'h421); idle(5);
    check({31'h0, irq_out}, 32'h1, "R4 high match sets flag");
    wr(4'hC, 32'h40);
    wr(4'h4, 32'd20); wr(4'h8, 32'd3); wr(4'h0, 32'd0);
    wr(4'hC, 32'h421); idle(12);
    check({31'h0, irq_out}, 32'h0, "R4 low wrap not a source");
    wr(4'hC, 32'h40);

    // R5 acknowledge colliding with a new event (low mark zero)
    wr(4'h4, 32'd0); wr(4'h8, 32'd0); wr(4'h0, 32'd0);
    wr(4'hC, 32'h21); idle(3);
    wr(4'hC, 32'h61); rd(4'hC, v); check(v & 32'h40, 32'h40, "R5 set wins over clear");
    wr(4'hC, 32'h20);
    wr(4'hC, 32'h20); rd(4'hC, v); check(v, 32'h60, "R5 zero leaves flag");
    check({31'h0, irq_out}, 32'h1, "R6 irq with flag and enable");
    wr(4'hC, 32'h0); rd(4'hC, v); check(v, 32'h40, "R9 flag kept after stop");
    check({31'h0, irq_out}, 32'h0, "R9 irq masked");
    wr(4'hC, 32'h40); rd(4'hC, v); check(v, 32'h0, "R5 ack clears");

    // R10 reset mid-run
    wr(4'h4, 32'd5); wr(4'h8, 32'd7); wr(4'hC, 32'h29); idle(4);
    @(posedge clk); #1 rst = 1'b1; @(posedge clk); #1 rst = 1'b0;
    rd(4'hC, v); check(v, 32'h0, "R10 ctrl cleared");
    rd(4'h4, v); check(v, 32'h0, "R10 high mark cleared");
    rd(4'h0, v); check(v, 32'h0, "R10 count cleared");

    // random register traffic, checked each cycle by the model
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      case ($urandom_range(0, 4))
        0: a = 4'h0; 1: a = 4'h4; 2: a = 4'h8; 3: a = 4'hC; default: a = 4'h6;
      endcase
      bus_addr = a;
      bus_wr   = ($urandom_range(0, 7) == 0);
      if (a == 4'hC) bus_wdata = $urandom() | ($urandom_range(0, 3) != 0 ? 32'h1 : 32'h0);
      else           bus_wdata = $urandom_range(0, 15);
    end
    @(posedge clk); #1 bus_wr = 1'b0;
    idle(2);
    finish_run();
  end

endmodule